// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Tick Scaling

This block is a watchdog timer on a simple memory-mapped register bus. It counts down a 20-bit tick counter. When the counter runs out it can raise a one-clock system reset pulse. The watchdog tick is derived from a 32.768 kHz tick-enable strobe. A 4-bit resolution value R sets the tick length to 1/2^R of a second, which is one watchdog tick every 2^(15-R) strobes.

Software works through two 32-bit words. The control word at offset 0x0 is read-write. The status word at offset 0x4 is read-only and shows the ticks remaining. A new reload count is not copied into the counter at once. A load-in-progress flag is raised, and it stays set until four strobe periods have passed and the counter has taken the new value. Software polls this flag before it relies on the count. Software starts the watchdog by writing a count together with the run and reset-arm bits, and stops it by clearing those two bits.

Top module: `sec_wdog`

## Requirements
- R1: After reset, both words read 0x00000000 and the reset pulse output is low.
- R2: Control word layout. Bits 19:0 hold the reload count. Bits 23:20 hold R. Bit 26 arms the reset on expiry. Bit 27 enables counting. Bit 28 is the load flag and is read-only. Bits 31:29, 25 and 24 read as zero.
- R3: A control write whose bits 19:0 differ from the held reload count sets the load flag (bit 28 of both words), visible in the cycle after the write. A write with an unchanged count leaves the flag clear.
- R4: The counter takes the new count on the fourth strobe after the write, and the load flag clears in that same cycle. Status bits 19:0 then show the new count.
- R5: While the load flag is set, the count field of a control write is ignored. Its run, reset-arm and R fields still take effect.
- R6: While enabled and not loading, the counter drops by one every 2^(15-R) strobes.
- R7: With the run bit clear, the counter holds its value.
- R8: When an enabled counter steps from 1 to 0 with the reset arm set, the reset output is high for exactly one clock. The counter then stays at 0.
- R9: Expiry with the reset arm clear gives no pulse, and the counter stays at 0.
- R10: A control write that changes R restarts the tick division, so the next tick comes a full new period (2^(15-R) strobes) after the write.
- R11: A reload while the watchdog is running replaces the remaining count and restarts the tick division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock strobe at 32.768 kHz |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_pulse | output | 1 | One-clock system reset on expiry |

## Verification
A load can complete in the same cycle that a tick would have decremented the counter. A control write can also land on the edge where the load flag clears. In both cases the load wins: the tick is dropped, the division restarts, and a count written while the flag is still set is discarded. The bench provokes these cases by reloading a running watchdog and by writing new fields while a load is pending. The strobe runs every four clocks, so such edges occur often. A behavioural model steps alongside the design, and on every clock the bench compares the word on the bus and the reset pulse against it.

// File: rtl/sec_wdog_pkg.sv
package sec_wdog_pkg;
  localparam int CNT_W     = 20;
  localparam int RES_W     = 4;
  localparam int MAX_RES   = 15;
  localparam int RES_LO    = 20;
  localparam int RSTEN_BIT = 26;
  localparam int EN_BIT    = 27;
  localparam int BUSY_BIT  = 28;
  localparam logic [7:0] CTRL_OFS  = 8'h00;
  localparam logic [7:0] COUNT_OFS = 8'h04;
endpackage

// File: rtl/sec_wdog_presc.sv
module sec_wdog_presc #(
  parameter int RES_W   = 4,
  parameter int MAX_RES = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             restart,
  input  logic [RES_W-1:0] res,
  output logic             wd_tick
);
  localparam int PW = (MAX_RES > 0) ? MAX_RES : 1;

  logic [PW-1:0] cnt_q, cnt_d;
  logic [31:0]   lim;
  logic          at_lim;

  assign lim     = (32'd1 << (MAX_RES - int'(res))) - 32'd1;
  assign at_lim  = (32'(cnt_q) == lim);
  assign wd_tick = run && tick_en && at_lim && !restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (run && tick_en)
      cnt_d = at_lim ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_tick |-> tick_en); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/sec_wdog_load.sv
module sec_wdog_load #(
  parameter int LOAD_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int LW = (LOAD_DLY > 1) ? $clog2(LOAD_DLY) : 1;

  logic [LW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign done = busy && tick_en && (cnt_q == LW'(LOAD_DLY - 1));

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy && tick_en) begin
      cnt_d = cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end

  AST_LOAD_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick_en)); // R4
endmodule

// File: rtl/sec_wdog_ctr.sv
module sec_wdog_ctr #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic          rsten,
  output logic [CW-1:0] value,
  output logic          expire
);
  logic [CW-1:0] val_d;
  logic          exp_d;

  always_comb begin
    val_d = value;
    if (load)
      val_d = load_val;
    else if (dec && (value != '0))
      val_d = value - CW'(1);
    exp_d = dec && !load && (value == CW'(1)) && rsten;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      expire <= 1'b0;
    end else begin
      value  <= val_d;
      expire <= exp_d;
    end
  end

  AST_EXPIRE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R8
  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (value == '0)); // R8
  AST_EXPIRE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(rsten)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((value != $past(value)) && !$past(load)) |-> (value == $past(value) - CW'(1))); // R6
endmodule

// File: rtl/sec_wdog.sv
module sec_wdog
  import sec_wdog_pkg::*;
#(
  parameter int LOAD_DLY = 4,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_pulse
);
  logic             ctrl_wr;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             en_q, en_d, rsten_q, rsten_d;
  logic             ld_start, ld_busy, ld_done;
  logic             presc_restart, presc_run, wd_tick;
  logic [CNT_W-1:0] cnt_val;
  logic             unused_wbits;

  assign ctrl_wr      = bus_sel && bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
  assign unused_wbits = ^{bus_wdata[31:BUSY_BIT], bus_wdata[RSTEN_BIT-1:RES_LO+RES_W]};

  always_comb begin
    rld_d    = rld_q;
    res_d    = res_q;
    en_d     = en_q;
    rsten_d  = rsten_q;
    ld_start = 1'b0;
    if (ctrl_wr) begin
      res_d   = bus_wdata[RES_LO +: RES_W];
      en_d    = bus_wdata[EN_BIT];
      rsten_d = bus_wdata[RSTEN_BIT];
      if (!ld_busy && (bus_wdata[CNT_W-1:0] != rld_q)) begin
        rld_d    = bus_wdata[CNT_W-1:0];
        ld_start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q   <= '0;
      res_q   <= '0;
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
    end else if (ctrl_wr) begin
      rld_q   <= rld_d;
      res_q   <= res_d;
      en_q    <= en_d;
      rsten_q <= rsten_d;
    end
  end

  assign presc_restart = ld_done || (ctrl_wr && (bus_wdata[RES_LO +: RES_W] != res_q));
  assign presc_run     = en_q && !ld_busy && (cnt_val != '0);

  sec_wdog_load #(.LOAD_DLY(LOAD_DLY)) u_load (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .start(ld_start), .busy(ld_busy), .done(ld_done)
  );

  sec_wdog_presc #(.RES_W(RES_W), .MAX_RES(MAX_RES)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(presc_run),
    .restart(presc_restart), .res(res_q), .wd_tick(wd_tick)
  );

  sec_wdog_ctr #(.CW(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld_done), .load_val(rld_q),
    .dec(wd_tick), .rsten(rsten_q), .value(cnt_val), .expire(sys_rst_pulse)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS)) begin
      bus_rdata[CNT_W-1:0]       = rld_q;
      bus_rdata[RES_LO +: RES_W] = res_q;
      bus_rdata[RSTEN_BIT]       = rsten_q;
      bus_rdata[EN_BIT]          = en_q;
      bus_rdata[BUSY_BIT]        = ld_busy;
    end else if (bus_addr == ADDR_W'(COUNT_OFS)) begin
      bus_rdata[CNT_W-1:0]       = cnt_val;
      bus_rdata[BUSY_BIT]        = ld_busy;
    end
  end

  AST_LOAD_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ld_busy && (bus_wdata[CNT_W-1:0] != rld_q)) |=> ld_busy); // R3
  AST_COUNT_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ld_busy) |=> $stable(rld_q)); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ld_done) |=> $stable(cnt_val)); // R7
endmodule

// File: tb/sec_wdog_bench.sv
module sec_wdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        sys_rst_pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  sec_wdog u_sec_wdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_pulse(sys_rst_pulse)
  );

  always #2 clk = ~clk;

  // strobe every fourth clock, changed just after the edge
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph = (ph + 1) % 4;
      tick_en = (ph == 0);
    end
  end

  always @(posedge clk) cyc++;

  // behavioural reference model
  logic [19:0] m_fld, m_ctr;
  logic [3:0]  m_res;
  bit m_en, m_arm, m_busy, m_pulse;
  int m_ldc, m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fld = 0; m_ctr = 0; m_res = 0; m_en = 0; m_arm = 0;
      m_busy = 0; m_pulse = 0; m_ldc = 0; m_div = 0;
    end else begin
      bit wr, fin, go, rs, tk;
      int period;
      logic [19:0] o_fld, o_ctr; logic [3:0] o_res; bit o_en, o_arm, o_busy; int o_ldc;
      o_fld = m_fld; o_ctr = m_ctr; o_res = m_res; o_en = m_en; o_arm = m_arm;
      o_busy = m_busy; o_ldc = m_ldc;
      wr = bus_sel && bus_we && (bus_addr == 4'h0);
      fin = o_busy && tick_en && (o_ldc == 3);
      period = 1 << (15 - int'(o_res));
      go = o_en && !o_busy && (o_ctr != 0);
      rs = fin || (wr && (bus_wdata[23:20] != o_res));
      tk = go && tick_en && (m_div == period - 1) && !rs;
      if (rs) m_div = 0;
      else if (go && tick_en) m_div = (m_div == period - 1) ? 0 : m_div + 1;
      if (o_busy && tick_en) m_ldc = o_ldc + 1;
      if (fin) begin m_busy = 0; m_ctr = o_fld; end
      else if (tk) m_ctr = o_ctr - 1;
      m_pulse = tk && !fin && (o_ctr == 1) && o_arm;
      if (wr) begin
        m_res = bus_wdata[23:20]; m_en = bus_wdata[27]; m_arm = bus_wdata[26];
        if (!o_busy && bus_wdata[19:0] != o_fld) begin
          m_fld = bus_wdata[19:0]; m_busy = 1; m_ldc = 0;
        end
      end
    end
  end

  function automatic logic [31:0] model_word(logic [3:0] a);
    if (a == 4'h0) return {3'b0, m_busy, m_en, m_arm, 2'b0, m_res, m_fld};
    if (a == 4'h4) return {3'b0, m_busy, 8'b0, m_ctr};
    return 32'h0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] e;
      e = model_word(bus_addr);
      check(bus_rdata === e, (bus_addr == 4'h0) ? "R2 model ctrl" : "R6 model count",
            bus_rdata, e);
      check(sys_rst_pulse === m_pulse, "R8 model pulse",
            {31'b0, sys_rst_pulse}, {31'b0, m_pulse});
    end
  end

  int pulses = 0, run_len = 0, max_run = 0;
  always @(negedge clk) begin
    if (sys_rst_pulse) begin
      pulses++; run_len++;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  task automatic wr_ctrl(logic [31:0] d, output int at);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = 4'h0; bus_wdata = d;
    @(posedge clk); #1;
    at = cyc;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(4'h0, v);
      if (!v[28]) break;
    end
  endtask

  task automatic wait_change(output int at);
    logic [31:0] v0, v;
    rd(4'h4, v0);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      v = bus_rdata;
      if (v[19:0] != v0[19:0]) begin at = cyc; break; end
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog timeout", 0, 0);
    summary();
  end

  initial begin
    logic [31:0] v, v2;
    int tw, t1, t2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); check(v == 32'h0, "R1 ctrl after reset", v, 32'h0);
    rd(4'h4, v); check(v == 32'h0, "R1 count after reset", v, 32'h0);
    check(sys_rst_pulse == 1'b0, "R1 pulse low", {31'b0, sys_rst_pulse}, 0);

    // R2 layout and R3 flag set
    wr_ctrl(32'hFFFF_FFFF, tw);
    rd(4'h0, v); check(v == 32'h1CFF_FFFF, "R2 R3 ctrl layout and flag", v, 32'h1CFF_FFFF);
    wr_ctrl(32'h00FF_FFFF, tw);
    wait_idle();
    rd(4'h4, v); check(v == 32'h000F_FFFF, "R4 count loaded", v, 32'h000F_FFFF);

    // R5 count field ignored while loading
    wr_ctrl(32'h00F0_0005, tw);
    wr_ctrl(32'h08E0_0009, tw);
    rd(4'h0, v); check(v == 32'h18E0_0005, "R5 fields during load", v, 32'h18E0_0005);
    wait_idle();
    rd(4'h4, v); check(v == 32'h0000_0005, "R4 R5 loaded value", v, 32'h5);

    // R6 tick period at R=14: 2 strobes = 8 clocks
    wait_change(t1);
    wait_change(t2);
    check((t2 - t1) == 8, "R6 tick spacing", t2 - t1, 8);

    // R7 hold when disabled
    wr_ctrl(32'h00E0_0005, tw);
    rd(4'h4, v);
    repeat (40) @(posedge clk);
    rd(4'h4, v2); check(v2 == v, "R7 hold while off", v2, v);

    // R9 expiry without reset arm
    pulses = 0;
    wr_ctrl(32'h08E0_0005, tw);
    repeat (100) @(posedge clk);
    rd(4'h4, v); check(v == 32'h0, "R9 counter at zero", v, 0);
    check(pulses == 0, "R9 no pulse", pulses, 0);

    // R8 expiry with reset arm
    pulses = 0; max_run = 0;
    wr_ctrl(32'h0CF0_0003, tw);
    repeat (100) @(posedge clk);
    check(pulses == 1, "R8 one pulse", pulses, 1);
    check(max_run == 1, "R8 pulse width", max_run, 1);
    rd(4'h4, v); check(v == 32'h0, "R8 stays zero", v, 0);

    // R3 unchanged count leaves flag clear
    wr_ctrl(32'h0CF0_0003, tw);
    rd(4'h0, v); check(v == 32'h0CF0_0003, "R3 no load on same count", v, 32'h0CF0_0003);

    // R10 restart on resolution change
    wr_ctrl(32'h08D0_0014, tw);
    wait_idle();
    wait_change(t1);
    repeat (5) @(posedge clk);
    wr_ctrl(32'h08C0_0014, tw);
    wait_change(t2);
    check((t2 - tw) >= 29 && (t2 - tw) <= 32, "R10 full period after R change", t2 - tw, 32);

    // R11 reload while running
    wr_ctrl(32'h08D0_0032, tw);
    wait_idle();
    rd(4'h4, v); check(v == 32'h0000_0032, "R11 reload while running", v, 32'h32);
    wr_ctrl(32'h00D0_0032, tw);
    repeat (20) @(posedge clk);

    summary();
  end
endmodule